// File: doc/BRIEF.md
# BPSK Carrier Modulator with Table-Driven Synthesis

This block turns a serial bit stream into a binary phase-shift keyed passband waveform. It runs at a sample rate of 80 Msps and places a 5 MHz carrier in the sampled domain. The output sample is s[n] = cos(2π·5n/80 + φ[n]), where φ[n] is 0 or π and follows the current data bit. A symbol lasts 80 samples, which gives 1 Mbaud.

An 8-bit phase accumulator steps by 16 on each enabled sample. Modulation adds half a turn (128 modulo 256) to the accumulator value. The resulting address reads a 256-entry signed cosine table, and the read is registered into the output sample. Data bits arrive on a ready/valid handshake. The block accepts a bit only at a symbol boundary. If no bit is offered there, the block keeps the previous phase and flags the underrun.

The clock enable pauses the whole datapath. Upstream logic uses it to set the sample cadence. Downstream, the signed sample and its valid strobe feed a converter interface.

Top module: `bpsk_dds_mod`

## Requirements
- R1: After reset the accumulator and the symbol counter are zero and `sample_valid_o`, `underflow_o` are low. The first enabled cycle is therefore a symbol boundary, and a 0 bit accepted there yields a first sample of 32767.
- R2: Each enabled cycle advances the phase address by 16 modulo 256, so the carrier repeats every 16 samples. At every symbol boundary the accumulator is back at 0.
- R3: Each sample equals round(32767·cos(2π·a/256)), rounded to nearest, where a = (accumulator + 128·b) mod 256 and b is the bit in force. Bit value 0 gives phase 0 and bit value 1 gives phase π.
- R4: `bit_ready_o` is high in an enabled cycle exactly when the symbol counter is 0. This happens once every 80 enabled cycles and never in two consecutive cycles.
- R5: A bit is taken only when `bit_ready_o` and `bit_valid_i` are both high. It applies from the sample produced in that same cycle. `bit_valid_i` and `bit_i` have no effect in any other cycle.
- R6: When a boundary passes without `bit_valid_i`, the previous bit stays in force for the next symbol. `underflow_o` is high together with the first sample of that symbol, and only then.
- R7: While `en_i` is low, the phase and the symbol counter do not move and no sample is produced. The waveform resumes exactly where it stopped.
- R8: `sample_valid_o` follows `en_i` with one clock of latency. The table address presented in an enabled cycle appears on `sample_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advances the modulator by one sample |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_i | input | 1 | Data bit: 0 keeps phase 0, 1 shifts by π |
| bit_ready_o | output | 1 | Symbol boundary: offered bit is taken this cycle |
| sample_o | output | 16 | Signed cosine sample |
| sample_valid_o | output | 1 | `sample_o` holds a new sample |
| underflow_o | output | 1 | First sample of a symbol repeated for lack of data |

## Verification
The hardest case is an underrun where the held bit is 1 and an enable gap falls right at the boundary. The boundary then lands on a different clock from the one a free-running count predicts. The bench drives symbol streams in which `bit_i` toggles while `bit_valid_i` stays high mid-symbol, so any bit taken early would show up as a phase flip. It withholds valid at chosen boundaries after both bit values. It drops `en_i` for runs that straddle a boundary. A reference model steps only on enabled cycles and predicts every sample, ready level and underflow pulse.

// File: rtl/bpsk_dds_pkg.sv
package bpsk_dds_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // nearest-integer amplitude of cos(2*pi*idx/depth)
  function automatic int cos_entry(input int idx, input int depth, input int amp);
    real ang;
    real val;
    ang = TWO_PI * real'(idx) / real'(depth);
    val = real'(amp) * $cos(ang);
    if (val >= 0.0) return $rtoi(val + 0.5);
    else return -$rtoi(-val + 0.5);
  endfunction

endpackage

// File: rtl/bpsk_phase_acc.sv
module bpsk_phase_acc #(
  parameter int PHASE_W = 8,
  parameter int STEP    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  output logic [PHASE_W-1:0] phase_o
);

  localparam logic [PHASE_W-1:0] STEP_V = PHASE_W'(STEP);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= phase_q + STEP_V;
  end

  assign phase_o = phase_q;

  AST_PHASE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q)); // R7

endmodule

// File: rtl/bpsk_sym_ctrl.sv
module bpsk_sym_ctrl #(
  parameter int SPS = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic ready_o,
  output logic cur_bit_o,
  output logic uf_o
);

  localparam int CNT_W = (SPS > 1) ? $clog2(SPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SPS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bit_q;
  logic             boundary;
  logic             take;

  assign boundary  = (cnt_q == '0);
  assign ready_o   = en_i && boundary;
  assign take      = ready_o && valid_i;
  assign cur_bit_o = take ? bit_i : bit_q;
  assign uf_o      = ready_o && !valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_q <= 1'b0;
    else if (take) bit_q <= bit_i;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
  AST_READY_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R4
  AST_CNT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R7
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && valid_i) |=> $stable(bit_q)); // R5

endmodule

// File: rtl/bpsk_cos_rom.sv
module bpsk_cos_rom #(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 32767
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       uf_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sample_valid_o,
  output logic                       underflow_o
);

  import bpsk_dds_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [SAMPLE_W-1:0] lut_w [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_lut
    localparam int VAL = cos_entry(gi, DEPTH, AMP);
    assign lut_w[gi] = SAMPLE_W'(VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
      underflow_o    <= 1'b0;
    end else begin
      sample_valid_o <= en_i;
      underflow_o    <= en_i && uf_i;
      if (en_i) sample_o <= lut_w[addr_i];
    end
  end

  AST_VALID_ON_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> sample_valid_o); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sample_valid_o); // R8
  AST_SAMPLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sample_o)); // R7

endmodule

// File: rtl/bpsk_dds_mod.sv
module bpsk_dds_mod #(
  parameter int PHASE_W  = 8,
  parameter int STEP     = 16,
  parameter int SPS      = 80,
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 32767
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       bit_valid_i,
  input  logic                       bit_i,
  output logic                       bit_ready_o,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sample_valid_o,
  output logic                       underflow_o
);

  localparam logic [PHASE_W-1:0] HALF_TURN = PHASE_W'(1 << (PHASE_W - 1));
  localparam bit ALIGNED = ((SPS * STEP) % (1 << PHASE_W)) == 0;

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] addr;
  logic               cur_bit;
  logic               uf;

  bpsk_phase_acc #(.PHASE_W(PHASE_W), .STEP(STEP)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .phase_o(phase)
  );

  bpsk_sym_ctrl #(.SPS(SPS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valid_i  (bit_valid_i),
    .bit_i    (bit_i),
    .ready_o  (bit_ready_o),
    .cur_bit_o(cur_bit),
    .uf_o     (uf)
  );

  // a 1 bit rotates the lookup by half a turn
  assign addr = phase + (cur_bit ? HALF_TURN : '0);

  bpsk_cos_rom #(.ADDR_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .AMP(AMP)) u_rom (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .addr_i        (addr),
    .uf_i          (uf),
    .sample_o      (sample_o),
    .sample_valid_o(sample_valid_o),
    .underflow_o   (underflow_o)
  );

  if (ALIGNED) begin : g_align_chk
    AST_PHASE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_ready_o |-> (phase == '0)); // R2
  end

  AST_UF_AFTER_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> ($past(bit_ready_o) && !$past(bit_valid_i))); // R6
  AST_UF_WITH_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> sample_valid_o); // R6

endmodule

// File: tb/bpsk_dds_mod_tb.sv
module bpsk_dds_mod_tb;

  localparam int SPS = 80;
  localparam int AMP = 32767;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        bit_valid_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_ready_o;
  logic signed [15:0] sample_o;
  logic        sample_valid_o;
  logic        underflow_o;

  bpsk_dds_mod u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .bit_ready_o(bit_ready_o),
    .sample_o(sample_o), .sample_valid_o(sample_valid_o), .underflow_o(underflow_o)
  );

  always #10 clk_i = ~clk_i; // 50 MHz

  typedef struct {
    int    smp;
    bit    uf;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   m_acc = 0;
  int   m_cnt = 0;
  int   m_bit = 0;
  bit   last_en = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int ref_cos(input int a);
    real v;
    v = real'(AMP) * $cos(6.283185307179586 * real'(a) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // driver: one clock of stimulus, expectation pushed for the monitor
  task automatic drive(input bit en, input bit vld, input bit b, input string req);
    bit   exp_rdy;
    exp_t e;
    @(negedge clk_i);
    check(sample_valid_o == last_en, "R8", int'(sample_valid_o), int'(last_en));
    en_i = en; bit_valid_i = vld; bit_i = b;
    #1;
    exp_rdy = en && (m_cnt == 0);
    check(bit_ready_o == exp_rdy, "R4", int'(bit_ready_o), int'(exp_rdy));
    if (en) begin
      e.uf = 1'b0;
      if (exp_rdy) begin
        if (vld) m_bit = int'(b);
        else e.uf = 1'b1;
      end
      e.smp = ref_cos((m_acc + 128 * m_bit) % 256);
      e.req = req;
      exp_q.push_back(e);
      m_acc = (m_acc + 16) % 256;
      m_cnt = (m_cnt + 1) % SPS;
    end
    last_en = en;
  endtask

  // monitor: pops and compares every produced sample
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && sample_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(sample_o == e.smp, e.req, int'(sample_o), e.smp);
          check(underflow_o == e.uf, "R6", int'(underflow_o), int'(e.uf));
        end
      end else if (rst_ni) begin
        check(!underflow_o, "R6", int'(underflow_o), 0);
      end
    end
  end

  // one symbol with valid held high; bit_i flips mid-symbol and must be ignored
  task automatic send_symbol(input bit b);
    for (int i = 0; i < SPS; i++) begin
      if (i == 0) drive(1'b1, 1'b1, b, "R3");
      else drive(1'b1, 1'b1, (i % 3 == 0) ? ~b : b, "R5");
    end
  endtask

  task automatic starve_symbol();
    for (int i = 0; i < SPS; i++) drive(1'b1, 1'b0, 1'b0, "R6");
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(sample_valid_o == 1'b0, "R1", int'(sample_valid_o), 0);
    check(underflow_o == 1'b0, "R1", int'(underflow_o), 0);
    check(bit_ready_o == 1'b0, "R1", int'(bit_ready_o), 0);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b0, "R7");
    // R1: first enabled cycle is a boundary; first sample 32767
    drive(1'b1, 1'b1, 1'b0, "R1");
    for (int i = 1; i < SPS; i++) drive(1'b1, 1'b1, (i % 2) == 1, "R2");
    send_symbol(1'b1);
    send_symbol(1'b1);
    send_symbol(1'b0);
    // R6: underrun after a 0, then after a 1
    starve_symbol();
    send_symbol(1'b1);
    starve_symbol();
    // R7: enable gaps mid-symbol and straddling a boundary
    for (int i = 0; i < SPS; i++) begin
      if (i == 20) for (int k = 0; k < 7; k++) drive(1'b0, 1'b1, 1'b0, "R7");
      drive(1'b1, i == 0, 1'b0, "R7");
    end
    for (int i = 0; i < SPS - 3; i++) drive(1'b1, 1'b1, 1'b1, "R3");
    drive(1'b1, 1'b1, 1'b1, "R3");
    drive(1'b1, 1'b1, 1'b1, "R3");
    drive(1'b1, 1'b1, 1'b1, "R3");
    for (int k = 0; k < 5; k++) drive(1'b0, 1'b1, 1'b0, "R7");
    // boundary after the gap: no valid, held bit is 1
    drive(1'b1, 1'b0, 1'b0, "R6");
    for (int i = 1; i < SPS; i++) drive(1'b1, 1'b1, 1'b0, "R5");
    send_symbol(1'b0);
    drive(1'b0, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b0, "R8");
    @(negedge clk_i);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule